// File: doc/BRIEF.md
# Byte/Word Lane Steering Decoder

This block sits between the 16-bit host connector of a removable memory card and the card's internal storage. The internal storage is a set of paired segments: each pair holds an even-byte segment and an odd-byte segment. From the two active-low card enables, the register-select line, output-enable, write-enable, address bit 0 and the pair-select address bits, the block works out four things. It decides which segments are selected and which host data lanes are driven. It decides whether the odd byte has to be moved down onto the low lane. It also decides whether the access goes to the attribute memory instead of the segments.

Writes pass through two gates. The first is a write-protect input. The second is a synchronous qualifier on each strobe. A write starts only after write-enable, and every card enable the access uses, have stayed low for FILT consecutive clock edges. Reads are decoded combinationally from the pins.

Top module: `lane_steer_decoder`

## Requirements
- R1: With both card enables high, no segment is selected, no write strobe is issued, the attribute memory is not selected and both lanes are undriven.
- R2: Common-memory access (register-select high) with enable 1 low, enable 2 high and address bit 0 low selects the even segment of the chosen pair. The low lane carries the even byte and the high lane is undriven.
- R3: Common-memory access with enable 1 low, enable 2 high and address bit 0 high selects the odd segment. The odd byte appears on the low lane, the high lane is undriven, and write data for the odd segment is taken from the low lane.
- R4: Common-memory access with enable 1 high and enable 2 low selects the odd segment and drives only the high lane, whatever address bit 0 is.
- R5: Common-memory access with both enables low selects both segments of the pair and drives the even byte on the low lane and the odd byte on the high lane, whatever address bit 0 is.
- R6: Pair p selects segment index 2p as its even segment and 2p+1 as its odd segment. A byte access selects exactly one segment and a word access exactly two.
- R7: With register-select low, no segment is selected and the attribute select is raised. Only the low lane is ever driven, carrying attribute data at even addresses and 8'hFF when enable 1 alone is low with address bit 0 high. Attribute writes occur only at even-byte positions.
- R8: Output-enable high leaves both lanes undriven whatever the other inputs are.
- R9: With write-protect high, no segment write strobe and no attribute write strobe is issued.
- R10: A write strobe is issued only after write-enable and each low card enable have all been sampled low on FILT consecutive rising edges, with output-enable high. A shorter pulse on any of these issues no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the strobe qualifier |
| rst_n | input | 1 | Active-low reset |
| ce1_n | input | 1 | Card enable for the low lane, active low |
| ce2_n | input | 1 | Card enable for the high lane, active low |
| reg_n | input | 1 | Low selects attribute memory |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| a0 | input | 1 | Address bit 0 (byte select) |
| bank | input | BANK_BITS | Top address bits choosing the segment pair |
| wp | input | 1 | Write-protect switch, high blocks writes |
| host_wdata | input | 16 | Data from the host lanes |
| mem_rd_even | input | 8 | Read data of the selected pair's even segment |
| mem_rd_odd | input | 8 | Read data of the selected pair's odd segment |
| attr_rd | input | 8 | Read data of the attribute memory |
| host_rdata | output | 16 | Data toward the host lanes |
| drv_lo | output | 1 | Drive enable for host lane bits 7:0 |
| drv_hi | output | 1 | Drive enable for host lane bits 15:8 |
| seg_sel | output | 2<<BANK_BITS | Per-segment select, active high |
| seg_rd | output | 1 | Segment read enable |
| seg_we | output | 2<<BANK_BITS | Per-segment write strobe |
| mem_wd_even | output | 8 | Write data for even segments |
| mem_wd_odd | output | 8 | Write data for odd segments |
| attr_sel | output | 1 | Attribute memory select |
| attr_we | output | 1 | Attribute memory write strobe |

## Verification
The bench builds the block with its default BANK_BITS of 2 and FILT of 3. Four pairs and eight segment selects are therefore present, and every pair index can be walked to confirm the even/odd index mapping. A qualifier length of three puts the boundary between a two-cycle pulse, which must be rejected, and a three-cycle pulse, which must be accepted, within a few cycles. The boundary is tested on write-enable and on a card enable separately.

// File: rtl/lane_steer_decoder.sv
module lane_steer_decoder #(
  parameter int BANK_BITS = 2,
  parameter int FILT = 3,
  localparam int PAIRS = 1 << BANK_BITS,
  localparam int SEGS = 2 * PAIRS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce1_n,
  input  logic                 ce2_n,
  input  logic                 reg_n,
  input  logic                 oe_n,
  input  logic                 we_n,
  input  logic                 a0,
  input  logic [BANK_BITS-1:0] bank,
  input  logic                 wp,
  input  logic [15:0]          host_wdata,
  input  logic [7:0]           mem_rd_even,
  input  logic [7:0]           mem_rd_odd,
  input  logic [7:0]           attr_rd,
  output logic [15:0]          host_rdata,
  output logic                 drv_lo,
  output logic                 drv_hi,
  output logic [SEGS-1:0]      seg_sel,
  output logic                 seg_rd,
  output logic [SEGS-1:0]      seg_we,
  output logic [7:0]           mem_wd_even,
  output logic [7:0]           mem_wd_odd,
  output logic                 attr_sel,
  output logic                 attr_we
);
  localparam int CW = $clog2(FILT + 1);

  logic [2:0] strb_n;
  logic [2:0] qual;
  assign strb_n = {we_n, ce2_n, ce1_n};

  for (genvar g = 0; g < 3; g++) begin : g_qual
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (strb_n[g])         cnt <= '0;
      else if (cnt != CW'(FILT))  cnt <= cnt + 1'b1;
    end
    assign qual[g] = !strb_n[g] && (cnt == CW'(FILT));
  end

  logic en_lo, en_hi, any_en, common, byte_lo, odd_low, use_even, use_odd, rd, wr_ok;
  assign en_lo    = !ce1_n;
  assign en_hi    = !ce2_n;
  assign any_en   = en_lo | en_hi;
  assign common   = reg_n;
  assign byte_lo  = en_lo & !en_hi;
  assign odd_low  = byte_lo & a0;
  assign use_even = en_lo & !odd_low;
  assign use_odd  = en_hi | odd_low;
  assign rd       = !oe_n;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic hit;
    assign hit = common && (bank == BANK_BITS'(p));
    assign seg_sel[2*p]   = hit & use_even;
    assign seg_sel[2*p+1] = hit & use_odd;
  end

  assign seg_rd = rd & common & any_en;
  assign drv_lo = rd & en_lo;
  assign drv_hi = rd & en_hi & common;

  assign host_rdata[15:8] = mem_rd_odd;
  assign host_rdata[7:0]  = common ? (odd_low ? mem_rd_odd : mem_rd_even)
                                   : (odd_low ? 8'hFF : attr_rd);

  assign wr_ok = qual[2] & (ce1_n | qual[0]) & (ce2_n | qual[1]) & any_en & oe_n & !wp;

  assign seg_we      = seg_sel & {SEGS{wr_ok}};
  assign mem_wd_even = host_wdata[7:0];
  assign mem_wd_odd  = byte_lo ? host_wdata[7:0] : host_wdata[15:8];
  assign attr_sel    = !common & any_en;
  assign attr_we     = wr_ok & !common & use_even;
endmodule

// File: rtl/lane_steer_decoder_chk.sv
module lane_steer_decoder_chk #(
  parameter int SEGS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ce1_n,
  input logic            ce2_n,
  input logic            reg_n,
  input logic            oe_n,
  input logic            we_n,
  input logic            wp,
  input logic            drv_lo,
  input logic            drv_hi,
  input logic [SEGS-1:0] seg_sel,
  input logic [SEGS-1:0] seg_we,
  input logic            attr_we
);
  assert_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n && ce2_n) |-> (seg_sel == '0 && !drv_lo && !drv_hi && seg_we == '0 && !attr_we));

  assert_seg_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_n && (ce1_n != ce2_n)) |-> ($countones(seg_sel) == 1));

  assert_word_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_n && !ce1_n && !ce2_n) |-> ($countones(seg_sel) == 2));

  assert_attr_noseg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_n |-> (seg_sel == '0 && !drv_hi));

  assert_oe_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!drv_lo && !drv_hi));

  assert_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wp |-> (seg_we == '0 && !attr_we));

  assert_we_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_we != '0) || attr_we) |-> (!we_n && $past(!we_n)));
endmodule

bind lane_steer_decoder lane_steer_decoder_chk #(.SEGS(SEGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .reg_n(reg_n),
  .oe_n(oe_n), .we_n(we_n), .wp(wp), .drv_lo(drv_lo), .drv_hi(drv_hi),
  .seg_sel(seg_sel), .seg_we(seg_we), .attr_we(attr_we)
);

// File: tb/tb_lane_steer_decoder.sv
module tb_lane_steer_decoder;
  localparam int BB = 2;
  localparam int FL = 3;
  localparam int NS = 2 << BB;

  logic clk = 0, rst_n = 0;
  logic ce1_n = 1, ce2_n = 1, reg_n = 1, oe_n = 1, we_n = 1, a0 = 0, wp = 0;
  logic [BB-1:0] bank = '0;
  logic [15:0] host_wdata = 16'hB7E1;
  logic [7:0] mem_rd_even = 8'h3C, mem_rd_odd = 8'hC3, attr_rd = 8'h5A;
  logic [15:0] host_rdata;
  logic drv_lo, drv_hi, seg_rd, attr_sel, attr_we;
  logic [NS-1:0] seg_sel, seg_we;
  logic [7:0] mem_wd_even, mem_wd_odd;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  lane_steer_decoder #(.BANK_BITS(BB), .FILT(FL)) dut (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .reg_n(reg_n),
    .oe_n(oe_n), .we_n(we_n), .a0(a0), .bank(bank), .wp(wp),
    .host_wdata(host_wdata), .mem_rd_even(mem_rd_even), .mem_rd_odd(mem_rd_odd),
    .attr_rd(attr_rd), .host_rdata(host_rdata), .drv_lo(drv_lo), .drv_hi(drv_hi),
    .seg_sel(seg_sel), .seg_rd(seg_rd), .seg_we(seg_we), .mem_wd_even(mem_wd_even),
    .mem_wd_odd(mem_wd_odd), .attr_sel(attr_sel), .attr_we(attr_we)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic c1, input logic c2, input logic r, input logic o, input logic a);
    ce1_n = c1; ce2_n = c2; reg_n = r; oe_n = o; a0 = a;
    #1;
  endtask

  task automatic t_standby_R1;
    set_pins(1, 1, 1, 0, 0);
    chk("R1 sel", 32'(seg_sel), 0);
    chk("R1 drv", {drv_hi, drv_lo}, 0);
    chk("R1 attr", attr_sel, 0);
    we_n = 0; cyc(FL + 2);
    chk("R1 we", 32'(seg_we), 0);
    we_n = 1; cyc(1);
  endtask

  task automatic t_reads_R2_R6;
    for (int p = 0; p < (1 << BB); p++) begin
      bank = BB'(p);
      set_pins(0, 1, 1, 0, 0);
      chk("R2 sel", 32'(seg_sel), 32'(1) << (2*p));
      chk("R2 drv", {drv_hi, drv_lo}, 2'b01);
      chk("R2 data", host_rdata[7:0], 8'h3C);
      set_pins(0, 1, 1, 0, 1);
      chk("R3 sel", 32'(seg_sel), 32'(1) << (2*p+1));
      chk("R3 data", host_rdata[7:0], 8'hC3);
      chk("R3 drv", {drv_hi, drv_lo}, 2'b01);
      chk("R3 wdata", mem_wd_odd, 8'hE1);
      for (int a = 0; a < 2; a++) begin
        set_pins(1, 0, 1, 0, a[0]);
        chk("R4 sel", 32'(seg_sel), 32'(1) << (2*p+1));
        chk("R4 drv", {drv_hi, drv_lo}, 2'b10);
        chk("R4 data", host_rdata[15:8], 8'hC3);
        set_pins(0, 0, 1, 0, a[0]);
        chk("R5 R6 sel", 32'(seg_sel), 32'(3) << (2*p));
        chk("R5 drv", {drv_hi, drv_lo}, 2'b11);
        chk("R5 data", 32'(host_rdata), 32'hC33C);
        chk("R5 wdata", {mem_wd_odd, mem_wd_even}, 16'hB7E1);
      end
    end
    bank = '0;
  endtask

  task automatic t_attr_R7;
    set_pins(0, 1, 0, 0, 0);
    chk("R7 sel", 32'(seg_sel), 0);
    chk("R7 asel", attr_sel, 1);
    chk("R7 data", host_rdata[7:0], 8'h5A);
    chk("R7 drv", {drv_hi, drv_lo}, 2'b01);
    set_pins(0, 1, 0, 0, 1);
    chk("R7 odd", host_rdata[7:0], 8'hFF);
    set_pins(0, 0, 0, 0, 0);
    chk("R7 word drv", {drv_hi, drv_lo}, 2'b01);
    set_pins(0, 1, 0, 1, 1);
    we_n = 0; cyc(FL + 2);
    chk("R7 odd no write", attr_we, 0);
    a0 = 0; #1;
    chk("R7 even write", attr_we, 1);
    we_n = 1; cyc(1);
  endtask

  task automatic t_oe_R8;
    for (int m = 0; m < 4; m++) begin
      set_pins(m[0], m[1], 1, 1, 0);
      chk("R8 float", {drv_hi, drv_lo}, 0);
    end
    set_pins(0, 0, 0, 1, 0);
    chk("R8 attr float", {drv_hi, drv_lo}, 0);
  endtask

  task automatic t_protect_R9;
    set_pins(0, 0, 1, 1, 0);
    wp = 1; we_n = 0; cyc(FL + 3);
    chk("R9 seg", 32'(seg_we), 0);
    reg_n = 0; #1;
    chk("R9 attr", attr_we, 0);
    we_n = 1; wp = 0; reg_n = 1; cyc(1);
  endtask

  task automatic t_filter_R10;
    bank = 2'd1;
    set_pins(0, 1, 1, 1, 0);
    cyc(FL + 1);
    we_n = 0;
    for (int k = 0; k < FL - 1; k++) begin
      cyc(1);
      chk("R10 early", 32'(seg_we), 0);
    end
    we_n = 1; cyc(2);
    chk("R10 short we", 32'(seg_we), 0);
    we_n = 0; cyc(FL);
    chk("R10 full we", 32'(seg_we), 32'h4);
    chk("R10 wdata", mem_wd_even, 8'hE1);
    we_n = 1; #1;
    chk("R10 release", 32'(seg_we), 0);
    set_pins(1, 1, 1, 1, 0);
    we_n = 0; cyc(FL + 2);
    ce2_n = 0; cyc(FL - 1);
    chk("R10 ce short", 32'(seg_we), 0);
    cyc(1);
    chk("R10 ce full", 32'(seg_we), 32'h8);
    we_n = 1; ce2_n = 1; bank = '0; cyc(1);
  endtask

  initial begin
    fork
      begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        chk("R1 reset", {32'(seg_we), 1'b0}, 0);
        t_standby_R1;
        t_reads_R2_R6;
        t_attr_R7;
        t_oe_R8;
        t_protect_R9;
        t_filter_R10;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule